// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block is the output stage of one compare channel of an 8-bit timer. The counter, the comparator and the interrupt flags live elsewhere. They reach this block as a one-cycle compare-match pulse, a counter-at-bottom pulse and a count-direction bit. From these, and from a 2-bit output mode field and a 2-bit waveform selector, the block keeps a one-bit compare output register. It also decides what the port pin shows. The pin carries either that register or the general port data bit, and the pin's direction always follows the data direction bit.

The register is a two-state machine with states `OC_LOW` and `OC_HIGH`. Its transitions are:
- `LOW->HIGH`: set, toggle, or initial load of 1.
- `HIGH->LOW`: clear, toggle, or initial load of 0.
- `HOLD`: no action.

The action in a cycle is chosen by a fixed priority:
1. Initial load.
2. Force strobe.
3. Compare match.
4. Bottom event.

Software can preload the register while the pin override is off. A new mode field value reaches the bottom-event logic only at the next compare match.

Top module: `ocp_unit`

## Requirements
- R1: A synchronous active-high reset sets `oc_state` to 0 and `cur_mode` to 00.
- R2: With `mode_field` = 00 and `cur_mode` = 00, a compare match, bottom event or force strobe leaves `oc_state` unchanged in every waveform mode.
- R3: In the non-PWM modes (`wave_mode` 00 normal, 01 CTC), a compare match with `mode_field` 01 toggles `oc_state`, with 10 clears it and with 11 sets it, one clock later.
- R4: `pin_out` equals `oc_state` when `mode_field` is nonzero and `port_data` when it is 00, whatever `wave_mode` is.
- R5: `pin_oe` always equals `port_dir`.
- R6: `cur_mode` takes the value of `mode_field` only on a clock with `cmp_match` high, and the fast-PWM bottom action uses `cur_mode`, so a mode write takes effect at the first compare match after it.
- R7: In the non-PWM modes, `force_strobe` applies the `mode_field` action (01 toggle, 10 clear, 11 set) on the next clock, and takes priority over a compare match in the same cycle.
- R8: In the PWM modes (`wave_mode` 10 fast, 11 phase-correct), `force_strobe` has no effect.
- R9: In fast PWM (`wave_mode` 10), a match with `mode_field` 10 clears and with 11 sets. A bottom event without a match sets when `cur_mode` is 10 and clears when it is 11. Mode 01 causes no register action.
- R10: In phase-correct PWM (`wave_mode` 11), a match with `mode_field` 10 clears while `count_down` is 0 and sets while it is 1. Mode 11 does the inverse, and mode 01 does nothing.
- R11: `init_load` with `mode_field` = 00 loads `init_value` into `oc_state` on the next clock, before any other action. When `mode_field` is nonzero, `init_load` is ignored.
- R12: Each clock applies at most one action, in the priority order initial load, force (non-PWM only), compare match, then fast-PWM bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match | input | 1 | Compare-match pulse from the comparator |
| at_bottom | input | 1 | Counter-at-bottom pulse |
| count_down | input | 1 | 1 while the counter counts down (phase-correct) |
| mode_field | input | 2 | Compare output mode as written by software |
| wave_mode | input | 2 | 00 normal, 01 CTC, 10 fast PWM, 11 phase-correct PWM |
| force_strobe | input | 1 | Force-compare strobe |
| init_load | input | 1 | Load strobe for the compare output register |
| init_value | input | 1 | Value for the initial load |
| port_data | input | 1 | General port data bit |
| port_dir | input | 1 | Data direction bit, 1 = output |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |
| oc_state | output | 1 | Compare output register |
| cur_mode | output | 2 | Mode field latched at the last compare match |

## Verification
The bench targets cases where one cycle carries several events:
- Force with a match in a non-PWM mode. A design with the wrong priority toggles twice and ends with the old value.
- Force in a PWM mode. A design that ignores the mode gate moves the register with no match.
- A mode write followed by a fast-PWM bottom. A design that applies the write at once uses the new mode at the bottom instead of the latched one.
- Initial loads while the override is on. A design that accepts them corrupts a running waveform.

Phase-correct matches in both count directions catch swapped set and clear. Changing `port_data` against `oc_state` catches a multiplexer that consults the waveform mode.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int MODE_W = 2;
    localparam int WAVE_W = 2;

    typedef enum logic [WAVE_W-1:0] {
        WV_NORMAL = 2'd0,
        WV_CTC    = 2'd1,
        WV_FAST   = 2'd2,
        WV_PHASE  = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;

    function automatic act_e nonpwm_action(input logic [MODE_W-1:0] f);
        act_e a;
        unique case (f)
            2'b01:   a = ACT_TGL;
            2'b10:   a = ACT_CLR;
            2'b11:   a = ACT_SET;
            default: a = ACT_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ocp_mode_hold.sv
module ocp_mode_hold
    import ocp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_match,
    input  logic [MODE_W-1:0] field_req,
    output logic [MODE_W-1:0] field_act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_act <= '0;
        end else if (cmp_match) begin
            field_act <= field_req;
        end
    end

endmodule

// File: rtl/ocp_action_dec.sv
module ocp_action_dec
    import ocp_pkg::*;
(
    input  wave_e             wave,
    input  logic [MODE_W-1:0] field_req,
    input  logic [MODE_W-1:0] field_act,
    input  logic              cmp_match,
    input  logic              at_bottom,
    input  logic              count_down,
    input  logic              force_strobe,
    output act_e              act
);

    logic is_pwm;

    always_comb begin
        is_pwm = (wave == WV_FAST) || (wave == WV_PHASE);
        act    = ACT_NONE;
        if (force_strobe && !is_pwm) begin
            act = nonpwm_action(field_req);
        end else if (cmp_match) begin
            unique case (wave)
                WV_NORMAL, WV_CTC: act = nonpwm_action(field_req);
                WV_FAST: begin
                    if (field_req == 2'b10)      act = ACT_CLR;
                    else if (field_req == 2'b11) act = ACT_SET;
                end
                WV_PHASE: begin
                    if (field_req == 2'b10)      act = count_down ? ACT_SET : ACT_CLR;
                    else if (field_req == 2'b11) act = count_down ? ACT_CLR : ACT_SET;
                end
            endcase
        end else if (at_bottom && wave == WV_FAST) begin
            if (field_act == 2'b10)      act = ACT_SET;
            else if (field_act == 2'b11) act = ACT_CLR;
        end
    end

endmodule

// File: rtl/ocp_pin_mux.sv
module ocp_pin_mux
    import ocp_pkg::*;
(
    input  logic [MODE_W-1:0] field_req,
    input  logic              oc_bit,
    input  logic              port_data,
    input  logic              port_dir,
    output logic              pin_out,
    output logic              pin_oe
);

    logic override_on;

    always_comb begin
        override_on = |field_req;
        pin_out     = override_on ? oc_bit : port_data;
        pin_oe      = port_dir;
    end

endmodule

// File: rtl/ocp_unit.sv
module ocp_unit
    import ocp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_match,
    input  logic              at_bottom,
    input  logic              count_down,
    input  logic [MODE_W-1:0] mode_field,
    input  logic [WAVE_W-1:0] wave_mode,
    input  logic              force_strobe,
    input  logic              init_load,
    input  logic              init_value,
    input  logic              port_data,
    input  logic              port_dir,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              oc_state,
    output logic [MODE_W-1:0] cur_mode
);

    oc_state_e state_q, state_d;
    act_e      act;
    logic      load_ok;

    ocp_mode_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .cmp_match (cmp_match),
        .field_req (mode_field),
        .field_act (cur_mode)
    );

    ocp_action_dec u_dec (
        .wave         (wave_e'(wave_mode)),
        .field_req    (mode_field),
        .field_act    (cur_mode),
        .cmp_match    (cmp_match),
        .at_bottom    (at_bottom),
        .count_down   (count_down),
        .force_strobe (force_strobe),
        .act          (act)
    );

    // Preload only while the pin override is off
    always_comb load_ok = init_load && (mode_field == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OC_LOW;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (load_ok) begin
            state_d = init_value ? OC_HIGH : OC_LOW;
        end else begin
            unique case (state_q)
                OC_LOW:  if (act == ACT_SET || act == ACT_TGL) state_d = OC_HIGH;
                OC_HIGH: if (act == ACT_CLR || act == ACT_TGL) state_d = OC_LOW;
            endcase
        end
    end

    // Outputs
    always_comb oc_state = (state_q == OC_HIGH);

    ocp_pin_mux u_mux (
        .field_req (mode_field),
        .oc_bit    (oc_state),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/ocp_unit_chk.sv
module ocp_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmp_match,
    input logic [1:0] mode_field,
    input logic [1:0] wave_mode,
    input logic       force_strobe,
    input logic       init_load,
    input logic       port_data,
    input logic       port_dir,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       oc_state,
    input logic [1:0] cur_mode
);

    assert_mode_zero_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_field == 2'b00 && cur_mode == 2'b00 && !init_load) |=> $stable(oc_state));

    assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (!wave_mode[1] && mode_field == 2'b01 && (cmp_match || force_strobe))
        |=> oc_state != $past(oc_state));

    assert_override_mux_R4: assert property (@(posedge clk) disable iff (rst)
        pin_out == ((mode_field != 2'b00) ? oc_state : port_data));

    assert_dir_gate_R5: assert property (@(posedge clk) disable iff (rst)
        pin_oe == port_dir);

    assert_mode_defer_R6: assert property (@(posedge clk) disable iff (rst)
        !cmp_match |=> $stable(cur_mode));

    assert_mode_latch_R6: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> cur_mode == $past(mode_field));

    assert_force_pwm_R8: assert property (@(posedge clk) disable iff (rst)
        (wave_mode[1] && force_strobe && !cmp_match && !init_load && cur_mode == 2'b00)
        |=> $stable(oc_state));

endmodule

bind ocp_unit ocp_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmp_match    (cmp_match),
    .mode_field   (mode_field),
    .wave_mode    (wave_mode),
    .force_strobe (force_strobe),
    .init_load    (init_load),
    .port_data    (port_data),
    .port_dir     (port_dir),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .oc_state     (oc_state),
    .cur_mode     (cur_mode)
);

// File: tb/ocp_unit_test.sv
`timescale 1ns/1ps
module ocp_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_match = 1'b0, at_bottom = 1'b0, count_down = 1'b0;
    logic [1:0] mode_field = 2'b00, wave_mode = 2'b00;
    logic       force_strobe = 1'b0, init_load = 1'b0, init_value = 1'b0;
    logic       port_data = 1'b0, port_dir = 1'b0;
    logic       pin_out, pin_oe, oc_state;
    logic [1:0] cur_mode;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural reference state
    int m_oc  = 0;
    int m_act = 0;

    always #10 clk = ~clk;

    ocp_unit uut (
        .clk(clk), .rst(rst), .cmp_match(cmp_match), .at_bottom(at_bottom),
        .count_down(count_down), .mode_field(mode_field), .wave_mode(wave_mode),
        .force_strobe(force_strobe), .init_load(init_load), .init_value(init_value),
        .port_data(port_data), .port_dir(port_dir), .pin_out(pin_out),
        .pin_oe(pin_oe), .oc_state(oc_state), .cur_mode(cur_mode)
    );

    function automatic int apply_code(int cur, int code);
        // code: 1 toggle, 2 clear, 3 set
        if (code == 1) return 1 - cur;
        if (code == 2) return 0;
        if (code == 3) return 1;
        return cur;
    endfunction

    always @(posedge clk) begin
        int nf, wv;
        nf = int'(mode_field);
        wv = int'(wave_mode);
        if (rst) begin
            m_oc  = 0;
            m_act = 0;
        end else begin
            if (init_load && nf == 0) begin
                m_oc = int'(init_value);
            end else if (force_strobe && wv < 2) begin
                m_oc = apply_code(m_oc, nf);
            end else if (cmp_match) begin
                if (wv < 2) m_oc = apply_code(m_oc, nf);
                else if (wv == 2) begin
                    if (nf == 2) m_oc = 0;
                    else if (nf == 3) m_oc = 1;
                end else begin
                    if (nf == 2) m_oc = count_down ? 1 : 0;
                    else if (nf == 3) m_oc = count_down ? 0 : 1;
                end
            end else if (at_bottom && wv == 2) begin
                if (m_act == 2) m_oc = 1;
                else if (m_act == 3) m_oc = 0;
            end
            if (cmp_match) m_act = nf;
        end
    end

    task automatic compare(input string tag);
        int exp_pin;
        exp_pin = (mode_field != 2'b00) ? m_oc : int'(port_data);
        tests++;
        if (int'(oc_state) != m_oc || int'(cur_mode) != m_act ||
            int'(pin_out) != exp_pin || pin_oe != port_dir) begin
            fails++;
            $display("FAIL %s: oc=%0d mode=%0d pin=%0d oe=%0d expected oc=%0d mode=%0d pin=%0d oe=%0d",
                     tag, oc_state, cur_mode, pin_out, pin_oe, m_oc, m_act, exp_pin, port_dir);
        end
    endtask

    task automatic step(input logic r, input logic cm, input logic bt, input logic dn,
                        input logic [1:0] f, input logic [1:0] w, input logic fs,
                        input logic ld, input logic lv, input logic pd, input logic pdir,
                        input string tag);
        @(negedge clk);
        rst = r; cmp_match = cm; at_bottom = bt; count_down = dn;
        mode_field = f; wave_mode = w; force_strobe = fs;
        init_load = ld; init_value = lv; port_data = pd; port_dir = pdir;
        #8;
        compare(tag);
    endtask

    task automatic idle(input logic [1:0] f, input logic [1:0] w, input logic pd,
                        input logic pdir, input string tag);
        step(0, 0, 0, 0, f, w, 0, 0, 0, pd, pdir, tag);
    endtask

    initial begin
        // R1: reset state
        step(1, 1, 1, 0, 2'b11, 2'b00, 1, 1, 1, 1, 1, "R1");
        step(1, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R1");
        idle(2'b00, 2'b00, 1, 1, "R1");

        // R11: preload with override off, ignored with override on
        step(0, 0, 0, 0, 2'b00, 2'b00, 0, 1, 1, 0, 1, "R11");
        idle(2'b00, 2'b00, 0, 1, "R11");
        step(0, 0, 0, 0, 2'b10, 2'b00, 0, 1, 0, 0, 1, "R11");
        idle(2'b10, 2'b00, 0, 1, "R11");

        // R4 / R5: override independent of waveform mode, direction gating
        for (int w = 0; w < 4; w++) begin
            idle(2'b01, 2'(w), 0, 1, "R4");
            idle(2'b00, 2'(w), 0, 0, "R4");
            idle(2'b11, 2'(w), 1, 0, "R5");
        end

        // R3: non-PWM compare actions, normal and CTC
        for (int w = 0; w < 2; w++) begin
            step(0, 1, 0, 0, 2'b01, 2'(w), 0, 0, 0, 0, 1, "R3");
            idle(2'b01, 2'(w), 0, 1, "R3");
            step(0, 1, 0, 0, 2'b01, 2'(w), 0, 0, 0, 0, 1, "R3");
            step(0, 1, 0, 0, 2'b11, 2'(w), 0, 0, 0, 0, 1, "R3");
            step(0, 1, 0, 0, 2'b10, 2'(w), 0, 0, 0, 0, 1, "R3");
            idle(2'b10, 2'(w), 1, 1, "R3");
        end

        // R2: mode 00 leaves the register alone in every mode
        step(0, 1, 0, 0, 2'b00, 2'b00, 0, 1, 1, 0, 1, "R2");
        for (int w = 0; w < 4; w++) begin
            step(0, 1, 1, 0, 2'b00, 2'(w), 1, 0, 0, 0, 1, "R2");
            step(0, 0, 1, 1, 2'b00, 2'(w), 1, 0, 0, 1, 1, "R2");
        end

        // R7: force in non-PWM, priority over a same-cycle match
        step(0, 0, 0, 0, 2'b10, 2'b00, 1, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 2'b11, 2'b01, 1, 0, 0, 0, 1, "R7");
        step(0, 1, 0, 0, 2'b01, 2'b00, 1, 0, 0, 0, 1, "R7");
        idle(2'b01, 2'b00, 1, 1, "R7");

        // R8: force ignored in PWM modes
        step(0, 1, 0, 0, 2'b00, 2'b10, 0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 2'b10, 2'b10, 1, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 2'b11, 2'b11, 1, 0, 0, 0, 1, "R8");
        idle(2'b11, 2'b11, 0, 1, "R8");

        // R9 / R6: fast PWM match/bottom, deferred mode change
        step(0, 1, 0, 0, 2'b10, 2'b10, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 1, 0, 2'b10, 2'b10, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 2'b11, 2'b10, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, 2'b11, 2'b10, 0, 0, 0, 0, 1, "R6");
        step(0, 1, 0, 0, 2'b11, 2'b10, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 1, 0, 2'b11, 2'b10, 0, 0, 0, 0, 1, "R9");
        step(0, 1, 1, 0, 2'b01, 2'b10, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 1, 0, 2'b01, 2'b10, 0, 0, 0, 0, 1, "R9");
        idle(2'b01, 2'b10, 1, 1, "R9");

        // R10: phase-correct in both directions
        step(0, 1, 0, 0, 2'b10, 2'b11, 0, 0, 0, 0, 1, "R10");
        step(0, 1, 0, 1, 2'b10, 2'b11, 0, 0, 0, 0, 1, "R10");
        step(0, 1, 0, 1, 2'b11, 2'b11, 0, 0, 0, 0, 1, "R10");
        step(0, 1, 0, 0, 2'b11, 2'b11, 0, 0, 0, 0, 1, "R10");
        step(0, 1, 1, 1, 2'b01, 2'b11, 0, 0, 0, 0, 1, "R10");
        idle(2'b01, 2'b11, 0, 1, "R10");

        // R12: random mixes of simultaneous events
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 200) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                 1'($urandom), 2'($urandom), 2'($urandom), ($urandom % 4) == 0,
                 ($urandom % 6) == 0, 1'($urandom), 1'($urandom), 1'($urandom), "R12");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule